// File: doc/BRIEF.md
# Function Output Row Router

This block holds one 8-bit configuration byte that software writes and reads back. The byte decides how a programmable digital function reaches a small row interconnect. The function's primary output can be placed on one of four primary row lines, and its auxiliary output on one of four auxiliary row lines. Each of the two placements has its own enable. Lines that are not selected are driven low.

When the function-type input names the SPI-slave function, the auxiliary fields take on a different job: they supply the active-low slave-select. That signal comes either from one of four auxiliary input lines or straight from a bit that firmware writes, so no extra pin is spent on it. In this mode the auxiliary row lines stay off. The two clock-resync bits are stored and read back only.

Top module: `fn_out_router`

## Requirements
- R1: After reset the stored byte reads 0x00, all eight row lines are 0 and `ss_n` is 1.
- R2: A write with `cfg_we` high loads `cfg_wdata` at the next rising clock edge. All eight bits read back unchanged on `cfg_rdata`. Before that edge the outputs still follow the old byte.
- R3: The byte's fields are: bits 7:6 the resync select (stored only), bit 5 the auxiliary enable, bits 4:3 the auxiliary select, bit 2 the primary enable and bits 1:0 the primary select. With bit 2 at 1, `row_pri[sel]` equals `func_pri`, where sel is bits 1:0, and the other primary lines are 0.
- R4: With bit 2 at 0, all primary row lines are 0.
- R5: When `func_type` is not 5, bit 5 at 1 drives `func_aux` onto `row_aux[sel]`, where sel is bits 4:3, and the other auxiliary lines are 0. With bit 5 at 0, all auxiliary lines are 0.
- R6: When `func_type` equals 5 (SPI slave), all auxiliary row lines are 0 for any field setting and any `func_aux` value.
- R7: In SPI-slave mode with bit 5 at 0, `ss_n` equals `aux_in[sel]`, where sel is bits 4:3.
- R8: In SPI-slave mode with bit 5 at 1, `ss_n` equals bit 3 of the byte, whatever the state of `aux_in`.
- R9: When `func_type` is not 5, `ss_n` is held at 1.
- R10: In SPI-slave mode the primary routing of R3 and R4 still applies, and carries the data-out signal given on `func_pri`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored configuration byte |
| func_type | input | 3 | Function type code; 5 selects SPI slave |
| func_pri | input | 1 | Function primary output (data-out when SPI slave) |
| func_aux | input | 1 | Function auxiliary output |
| aux_in | input | 4 | Auxiliary input lines, possible slave-select sources |
| row_pri | output | 4 | Primary row line drives |
| row_aux | output | 4 | Auxiliary row line drives |
| ss_n | output | 1 | Active-low slave select for the SPI-slave function |

## Verification
A configuration write can land in the same cycle as a change of function type. In that cycle the routing has to follow the old byte under the new type, and it may only switch to the new byte after the clock edge. The bench provokes this by putting random writes together with random type codes, with type 5 given extra weight. It compares every output just before the edge with a model that uses the old byte, then checks read-back after the edge. Directed steps flip the type into and out of SPI-slave mode while a write is in flight, and also toggle the slave-select source between an input line and the firmware bit.

// File: rtl/fn_out_router.sv
module fn_out_router #(
  parameter int SEL_W     = 2,
  parameter int FT_W      = 3,
  parameter int SPIS_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [FT_W-1:0]   func_type,
  input  logic              func_pri,
  input  logic              func_aux,
  input  logic [(1<<SEL_W)-1:0] aux_in,
  output logic [(1<<SEL_W)-1:0] row_pri,
  output logic [(1<<SEL_W)-1:0] row_aux,
  output logic              ss_n
);
  localparam int LINES   = 1 << SEL_W;
  localparam int PSEL_LO = 0;
  localparam int PEN_B   = PSEL_LO + SEL_W;
  localparam int ASEL_LO = PEN_B + 1;
  localparam int AEN_B   = ASEL_LO + SEL_W;

  logic [7:0]       cfg_q;
  logic             is_spis;
  logic             pri_en, aux_en;
  logic [SEL_W-1:0] pri_sel, aux_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;

  assign cfg_rdata = cfg_q;
  assign is_spis   = (func_type == FT_W'(SPIS_CODE));
  assign pri_en    = cfg_q[PEN_B];
  assign aux_en    = cfg_q[AEN_B];
  assign pri_sel   = cfg_q[PEN_B-1:PSEL_LO];
  assign aux_sel   = cfg_q[AEN_B-1:ASEL_LO];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign row_pri[i] = pri_en && (pri_sel == SEL_W'(i)) && func_pri;
    assign row_aux[i] = !is_spis && aux_en && (aux_sel == SEL_W'(i)) && func_aux;
  end

  always_comb begin
    if (!is_spis)    ss_n = 1'b1;
    else if (aux_en) ss_n = aux_sel[0];
    else             ss_n = aux_in[aux_sel];
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  a_r3_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_pri) && $onehot0(row_aux));
  a_r4_pri_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[2] |-> row_pri == '0);
  a_r6_spis_aux_off: assert property (@(posedge clk) disable iff (!rst_n)
    (func_type == FT_W'(SPIS_CODE)) |-> row_aux == '0);
  a_r8_fw_select: assert property (@(posedge clk) disable iff (!rst_n)
    (func_type == FT_W'(SPIS_CODE)) && cfg_rdata[5] |-> ss_n == cfg_rdata[3]);
  a_r9_ss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (func_type != FT_W'(SPIS_CODE)) |-> ss_n);
endmodule

// File: tb/fn_out_router_tb.sv
`timescale 1ns/1ps
module fn_out_router_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [2:0] func_type = 0;
  logic func_pri = 0, func_aux = 0;
  logic [3:0] aux_in = 0, row_pri, row_aux;
  logic ss_n;
  int checks = 0, errors = 0;
  logic [7:0] model = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fn_out_router u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .func_type(func_type), .func_pri(func_pri), .func_aux(func_aux),
    .aux_in(aux_in), .row_pri(row_pri), .row_aux(row_aux), .ss_n(ss_n));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pri(logic [7:0] r, logic p);
    return r[2] ? (4'(p) << r[1:0]) : 4'b0;
  endfunction
  function automatic logic [3:0] exp_aux(logic [7:0] r, logic [2:0] ft, logic a);
    return (ft != 3'd5 && r[5]) ? (4'(a) << r[4:3]) : 4'b0;
  endfunction
  function automatic logic exp_ss(logic [7:0] r, logic [2:0] ft, logic [3:0] ai);
    if (ft != 3'd5) return 1'b1;
    return r[5] ? r[3] : ai[r[4:3]];
  endfunction

  task automatic check_all();
    chk("R2 rdata", cfg_rdata, model);
    chk(func_type == 3'd5 ? "R10 row_pri" : (model[2] ? "R3 row_pri" : "R4 row_pri"),
        row_pri, exp_pri(model, func_pri));
    chk(func_type == 3'd5 ? "R6 row_aux" : "R5 row_aux", row_aux, exp_aux(model, func_type, func_aux));
    chk(func_type != 3'd5 ? "R9 ss_n" : (model[5] ? "R8 ss_n" : "R7 ss_n"),
        ss_n, exp_ss(model, func_type, aux_in));
  endtask

  task automatic step(logic we, logic [7:0] wd, logic [2:0] ft, logic p, logic a, logic [3:0] ai);
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; func_type = ft; func_pri = p; func_aux = a; aux_in = ai;
    #1 check_all();
    @(posedge clk);
    if (we) model = wd;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 rdata", cfg_rdata, 0);
    chk("R1 row_pri", row_pri, 0);
    chk("R1 row_aux", row_aux, 0);
    chk("R1 ss_n", ss_n, 1);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R3 every primary line, R5 every aux line
    for (int s = 0; s < 4; s++) begin
      step(1, 8'h24 | 8'(s) | 8'(s << 3), 3'd1, 1, 1, 4'h0);
      step(0, 0, 3'd1, 1, 1, 4'h0);
      chk("R3 line", row_pri, 4'b1 << s);
      chk("R5 line", row_aux, 4'b1 << s);
    end
    // R2 write together with entry to SPI-slave mode
    step(1, 8'hC2, 3'd5, 1, 1, 4'hF);
    step(0, 0, 3'd5, 1, 1, 4'hF);
    chk("R2 readback", cfg_rdata, 8'hC2);
    // R7 input line source, R8 firmware bit source
    for (int s = 0; s < 4; s++) begin
      step(1, 8'(s << 3), 3'd5, 0, 1, 4'b1 << s);
      step(0, 0, 3'd5, 0, 1, 4'b1 << s);
      chk("R7 pick", ss_n, 1);
      step(0, 0, 3'd5, 0, 1, ~(4'b1 << s));
      chk("R7 pick low", ss_n, 0);
    end
    step(1, 8'h28, 3'd5, 0, 1, 4'h0);
    step(0, 0, 3'd5, 0, 1, 4'h0);
    chk("R8 fw high", ss_n, 1);
    step(1, 8'h20, 3'd5, 1, 1, 4'hF);
    step(0, 0, 3'd5, 1, 1, 4'hF);
    chk("R8 fw low", ss_n, 0);
    chk("R6 aux off", row_aux, 0);
    step(1, 8'h20, 3'd2, 1, 1, 4'hF);
    chk("R9 leave spis", ss_n, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ft;
      ft = ($urandom % 3 == 0) ? 3'd5 : 3'($urandom);
      step(1'($urandom % 3 == 0), 8'($urandom), ft, 1'($urandom), 1'($urandom), 4'($urandom));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule